// File: doc/BRIEF.md
# Repeat-Loop Cycle Sequencer for Paged Program Reads

This block sets the cost, in cycles, of each iteration of a hardware-repeated instruction. The cost depends on how the instruction reaches program memory. The pipeline pulses `start` with a repeat count and a description of the instruction:

- whether it reads program space through the paged data window;
- whether it is a table read;
- the post-modify step of its pointer.

The block then owns the loop. On each cycle it says whether the pipeline must stall. It marks the last cycle of every iteration, and it flags the last cycle of the whole loop.

The paged window has a prefetch fast path. It applies only when the pointer steps by exactly +2 or -2 and the instruction is not a table read. In that case steady iterations cost one cycle. Other iterations carry fixed costs:

- the opening iteration costs five cycles;
- an iteration that borders an interrupt, on either side, costs five cycles;
- the closing iteration costs six cycles.

An interrupt request is looked at only where one iteration hands over to the next. When the request is taken, the loop parks after the current iteration. It resumes with its remaining count intact when the pipeline signals the return.

Top module: `rpt_cycle_ctrl`

## Requirements
- R1: With `tbl_rd` high at start, every iteration takes 5 cycles, the last one included, whatever `paged_rd` and `pm_step` are.
- R2: With `paged_rd` high, `tbl_rd` low and a step other than +2 or -2, every iteration takes 5 cycles. The step is a two's-complement value, so -2 is 16'hFFFE at the default width.
- R3: On the fast path (`paged_rd` high, `tbl_rd` low, step +2 or -2), an iteration that is neither first, nor last, nor next to an interrupt takes 1 cycle.
- R4: On the fast path, the first iteration of a loop takes 5 cycles, unless it is also the last one.
- R5: On the fast path, the last iteration takes 6 cycles. A count of 0 gives a single iteration of 6 cycles.
- R6: On the fast path, both of the following take 5 cycles, unless the iteration is the last:
  - an iteration that began with `irq_req` sampled high;
  - the first iteration after `irq_return`.
- R7: With `paged_rd` and `tbl_rd` both low, every iteration takes 1 cycle.
- R8: A count of N runs exactly N+1 iterations. `iter_done` is high for exactly one cycle per iteration. `loop_done` is high only together with the final `iter_done`, and the block is idle on the cycle after it.
- R9: `busy` is high on every cycle of an iteration except its last cycle, and low while idle or parked.
- R10: `irq_req` is sampled only at the start of an iteration.
  - When it is sampled high on a non-final iteration, `parked` rises after that iteration ends. The block stays parked until `irq_return`, then runs the remaining iterations.
  - When it is sampled high on the final iteration, the block does not park.
- R11: Configuration is captured when `start` is accepted. `start` and changes to the configuration inputs while a loop is running have no effect on iteration costs or count.
- R12: After reset, all four outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a repeated instruction (accepted when idle) |
| rpt_count | input | CNT_W | Repeat count; N gives N+1 iterations |
| paged_rd | input | 1 | Instruction reads through the paged program window |
| tbl_rd | input | 1 | Instruction is a table read |
| pm_step | input | OFS_W | Signed post-modify step of the pointer |
| irq_req | input | 1 | Interrupt pending, sampled at iteration starts |
| irq_return | input | 1 | Interrupt serviced, resume a parked loop |
| busy | output | 1 | Stall: iteration not yet in its last cycle |
| iter_done | output | 1 | Last cycle of an iteration |
| loop_done | output | 1 | Last cycle of the final iteration |
| parked | output | 1 | Loop suspended for an interrupt |

## Verification
Assertions check the following on every cycle:

- an iteration counter that is independent of the cost down-counter agrees with the fixed costs of the table, slow and plain modes;
- the fast-path final iteration lasts six cycles;
- the remaining count and the parked state hold still until the return event.

Only the bench scenarios can show the position-dependent costs: first, steady, pre-interrupt and re-entry iterations. They also show the total number of iterations, the choice not to park on the final iteration, and that configuration changes and `start` pulses mid-loop are ignored. The bench sweeps every interrupt pattern over short loops in each mode and compares every iteration's length with a cost it computes itself.

// File: rtl/rptc_pkg.sv
package rptc_pkg;

  localparam int COST_W = 3;

  typedef enum logic [1:0] {
    RM_PLAIN = 2'd0,
    RM_TABLE = 2'd1,
    RM_SLOW  = 2'd2,
    RM_FAST  = 2'd3
  } rpt_mode_e;

  // Mode from instruction flags; table read dominates the paged flag.
  function automatic rpt_mode_e pick_mode(input logic paged, input logic table_rd,
                                          input logic step_ok);
    if (table_rd)             return RM_TABLE;
    else if (paged && step_ok) return RM_FAST;
    else if (paged)           return RM_SLOW;
    else                      return RM_PLAIN;
  endfunction

  // Cycles spent on one iteration.
  function automatic logic [COST_W-1:0] iter_cost(input rpt_mode_e m, input logic first,
                                                  input logic last, input logic near_irq);
    logic [COST_W-1:0] c;
    unique case (m)
      RM_PLAIN: c = COST_W'(1);
      RM_TABLE: c = COST_W'(5);
      RM_SLOW:  c = COST_W'(5);
      default: begin
        if (last)                  c = COST_W'(6);
        else if (first || near_irq) c = COST_W'(5);
        else                       c = COST_W'(1);
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/rptc_mode_decode.sv
module rptc_mode_decode
  import rptc_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic             paged,
  input  logic             table_rd,
  input  logic [OFS_W-1:0] step,
  output rpt_mode_e        mode
);
  localparam logic [OFS_W-1:0] STEP_POS = OFS_W'(2);
  localparam logic [OFS_W-1:0] STEP_NEG = ~OFS_W'(1); // two's complement -2

  logic step_ok;
  assign step_ok = (step == STEP_POS) || (step == STEP_NEG);
  assign mode    = pick_mode(paged, table_rd, step_ok);
endmodule

// File: rtl/rptc_iter_count.sv
module rptc_iter_count #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] rem,
  output logic             on_final,
  output logic             next_final
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rem_q <= '0;
    else if (load) rem_q <= load_val;
    else if (step) rem_q <= rem_q - CNT_W'(1);
  end

  assign rem        = rem_q;
  assign on_final   = (rem_q == '0);
  assign next_final = (rem_q == CNT_W'(1));
endmodule

// File: rtl/rptc_cycle_timer.sv
module rptc_cycle_timer
  import rptc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COST_W-1:0] cost,
  output logic              at_end,
  output logic [COST_W-1:0] elapsed
);
  logic [COST_W-1:0] left_q;
  logic [COST_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left_q <= '0;
    else if (load)        left_q <= cost - COST_W'(1);
    else if (left_q != 0) left_q <= left_q - COST_W'(1);
  end

  // Up-counter kept apart from the down-counter, for checking.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           len_q <= '0;
    else if (load)        len_q <= '0;
    else if (left_q != 0) len_q <= len_q + COST_W'(1);
  end

  assign at_end  = (left_q == '0);
  assign elapsed = len_q;
endmodule

// File: rtl/rpt_cycle_ctrl.sv
module rpt_cycle_ctrl
  import rptc_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] rpt_count,
  input  logic             paged_rd,
  input  logic             tbl_rd,
  input  logic [OFS_W-1:0] pm_step,
  input  logic             irq_req,
  input  logic             irq_return,
  output logic             busy,
  output logic             iter_done,
  output logic             loop_done,
  output logic             parked
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PARK} st_e;

  st_e               st_q, st_d;
  rpt_mode_e         mode_in, mode_q, mode_use;
  logic              park_q;
  logic [CNT_W-1:0]  rem;
  logic              on_final, next_final;
  logic              at_end;
  logic [COST_W-1:0] elapsed;
  logic [COST_W-1:0] cost_new;

  // Named events
  logic running, go_start, iter_end, go_next, go_park, go_resume, iter_start;
  logic last_new, park_new;

  rptc_mode_decode #(.OFS_W(OFS_W)) u_decode (
    .paged(paged_rd), .table_rd(tbl_rd), .step(pm_step), .mode(mode_in)
  );

  assign running    = (st_q == ST_RUN);
  assign go_start   = (st_q == ST_IDLE) && start;
  assign iter_end   = running && at_end;
  assign go_next    = iter_end && !on_final && !park_q;
  assign go_park    = iter_end && !on_final && park_q;
  assign go_resume  = (st_q == ST_PARK) && irq_return;
  assign iter_start = go_start || go_next || go_resume;

  assign last_new = go_start ? (rpt_count == '0) : next_final;
  assign park_new = irq_req && !last_new;
  assign mode_use = go_start ? mode_in : mode_q;
  assign cost_new = iter_cost(mode_use, go_start, last_new, park_new || go_resume);

  rptc_iter_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(go_start), .load_val(rpt_count),
    .step(go_next || go_resume), .rem(rem), .on_final(on_final), .next_final(next_final)
  );

  rptc_cycle_timer u_timer (
    .clk(clk), .rst_n(rst_n), .load(iter_start), .cost(cost_new),
    .at_end(at_end), .elapsed(elapsed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_PLAIN;
      park_q <= 1'b0;
    end else begin
      if (go_start)   mode_q <= mode_in;
      if (iter_start) park_q <= park_new;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go_start) st_d = ST_RUN;
      ST_RUN: begin
        if (iter_end && on_final) st_d = ST_IDLE;
        else if (go_park)         st_d = ST_PARK;
      end
      ST_PARK: if (irq_return) st_d = ST_RUN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy      = running && !at_end;
  assign iter_done = iter_end;
  assign loop_done = iter_end && on_final;
  assign parked    = (st_q == ST_PARK);

  // Assertions
  a_r1_table_five: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && mode_q == RM_TABLE) |-> (elapsed == COST_W'(4)));
  a_r2_slow_five: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && mode_q == RM_SLOW) |-> (elapsed == COST_W'(4)));
  a_r7_plain_one: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_done && mode_q == RM_PLAIN) |-> (elapsed == COST_W'(0)));
  a_r5_fast_final_six: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_done && mode_q == RM_FAST) |-> (elapsed == COST_W'(5)));
  a_r10_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !irq_return) |=> (parked && $stable(rem)));
  a_r9_quiet_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> (!busy && !iter_done));
  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    loop_done |=> (!busy && !iter_done && !parked));
endmodule

// File: tb/rpt_cycle_ctrl_tb_top.sv
module rpt_cycle_ctrl_tb_top;
  localparam int CW = 4;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] rpt_count = '0;
  logic paged_rd = 1'b0, tbl_rd = 1'b0;
  logic [OW-1:0] pm_step = '0;
  logic irq_req = 1'b0, irq_return = 1'b0;
  logic busy, iter_done, loop_done, parked;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rpt_cycle_ctrl #(.CNT_W(CW), .OFS_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rpt_count(rpt_count),
    .paged_rd(paged_rd), .tbl_rd(tbl_rd), .pm_step(pm_step),
    .irq_req(irq_req), .irq_return(irq_return),
    .busy(busy), .iter_done(iter_done), .loop_done(loop_done), .parked(parked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected cost, restated from the requirements
  function automatic int want_len(input bit pg, input bit tb, input logic [OW-1:0] st,
                                  input int i, input int n, input bit pk, input bit re);
    bit quick;
    quick = pg && !tb && (st == 16'd2 || st == 16'hFFFE);
    if (tb) return 5;
    if (!pg) return 1;
    if (!quick) return 5;
    if (i == n) return 6;
    if (i == 0 || pk || re) return 5;
    return 1;
  endfunction

  function automatic string want_tag(input bit pg, input bit tb, input logic [OW-1:0] st,
                                     input int i, input int n, input bit pk, input bit re);
    bit quick;
    quick = pg && !tb && (st == 16'd2 || st == 16'hFFFE);
    if (tb) return "R1";
    if (!pg) return "R7";
    if (!quick) return "R2";
    if (i == n) return "R5";
    if (i == 0) return "R4";
    if (pk || re) return "R6";
    return "R3";
  endfunction

  task automatic run_case(input bit pg, input bit tb, input logic [OW-1:0] st,
                          input int n, input int mask, input bit poke);
    bit prev_pk;
    bit pk;
    int len;
    prev_pk = 0;
    @(negedge clk);
    paged_rd = pg; tbl_rd = tb; pm_step = st; rpt_count = CW'(n);
    irq_req = mask[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i <= n; i++) begin
      pk = mask[i] && (i != n);
      len = 0;
      forever begin
        len++;
        if (poke && len == 1) begin
          start = 1'b1; tbl_rd = ~tb; paged_rd = ~pg; pm_step = 16'd7; rpt_count = '1;
        end
        chk(busy == !iter_done, "R9", busy, !iter_done);
        if (iter_done || len > 10) break;
        @(negedge clk);
      end
      start = 1'b0;
      chk(len == want_len(pg, tb, st, i, n, pk, prev_pk),
          want_tag(pg, tb, st, i, n, pk, prev_pk), len, want_len(pg, tb, st, i, n, pk, prev_pk));
      chk(loop_done == (i == n), "R8", loop_done, (i == n));
      if (i < n) begin
        irq_req = mask[i+1];
        @(negedge clk);
        chk(parked == pk, "R10", parked, pk);
        if (pk) begin
          repeat (2) @(negedge clk);
          chk(parked && !busy && !iter_done, "R10", parked, 1);
          irq_return = 1'b1;
          @(negedge clk);
          irq_return = 1'b0;
        end
      end
      prev_pk = pk;
    end
    irq_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy && !iter_done && !parked, poke ? "R11" : "R8", busy | iter_done | parked, 0);
    end
    paged_rd = 1'b0; tbl_rd = 1'b0; pm_step = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !iter_done && !loop_done && !parked, "R12",
        busy | iter_done | loop_done | parked, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !iter_done && !parked, "R12", busy | iter_done | parked, 0);
    for (int c = 0; c < 7; c++) begin
      bit pg, tb;
      logic [OW-1:0] st;
      case (c)
        0: begin pg = 0; tb = 0; st = 16'd2;    end
        1: begin pg = 1; tb = 1; st = 16'd2;    end
        2: begin pg = 0; tb = 1; st = 16'hFFFE; end
        3: begin pg = 1; tb = 0; st = 16'd0;    end
        4: begin pg = 1; tb = 0; st = 16'd4;    end
        5: begin pg = 1; tb = 0; st = 16'd2;    end
        default: begin pg = 1; tb = 0; st = 16'hFFFE; end
      endcase
      for (int n = 0; n < 4; n++)
        for (int m = 0; m < (1 << (n + 1)); m++)
          run_case(pg, tb, st, n, m, bit'((c + n) % 2));
    end
    run_case(1, 0, 16'd2, 15, 0, 0);
    run_case(1, 0, 16'hFFFE, 15, 16'h8480, 1);
    run_case(1, 0, 16'd3, 15, 16'h0102, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule